// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a down-counting watchdog. It has a small register bus and a separate tick strobe that sets the counting rate. Software loads a time-out value, a warning compare value and a window value. Writing a two-byte key sequence to the kick register services the watchdog. A valid kick reloads the counter and also applies any mode changes written since the last kick.

The counter runs only after the enable bit has been committed by a kick. Along the way it raises a warning interrupt. When it reaches zero it flags a time-out. A kick that comes while the counter is still above the window value is refused as too early. A kick with a broken key sequence is also an error. The enable, reset-enable, protect and lock mode bits can only be set by software; a reset is the only way to clear them.

With reset-enable committed, every fault produces a one-cycle reset request. On that request the block returns to its reset state but keeps the time-out flag, so software can see the cause after the restart. With protect committed, the reload value can only be written while the counter sits below both the warning and window values.

Top module: `wwd_top`

## Requirements
- R1: After external reset the mode register (address 0) reads 0, the reload (address 1) and count (address 5) registers read RST_RELOAD (255), the warning value (address 2) reads 0, the window value (address 3) reads all ones, and irq, rst_req and osc_lock are low.
- R2: The mode bits enable (bit 0), reset-enable (bit 1), protect (bit 4) and lock (bit 5) are set by writing 1. Writing 0 to them has no effect. Only an external reset or a watchdog reset clears them.
- R3: A write to the mode register changes no committed mode bit on its own. A read of the mode register shows only committed bits, and the counter stays idle until a valid kick commits the enable bit.
- R4: A valid kick is a bus write of 0xAA to the kick register (address 4, low byte), followed by a write of 0x55 to the kick register as the very next bus write. It commits the pending mode bits and reloads the counter from the reload register.
- R5: A kick-register write of any value other than 0xAA with no sequence open is a feed error. So is any bus write after 0xAA that is not 0x55 to the kick register. A feed error sets the time-out flag (mode bit 2).
- R6: While enabled, the counter drops by one on each cycle with tick high and holds at zero. It never rises except through a kick reload or a reset.
- R7: When a decrement brings the counter to the warning value, the warning flag (mode bit 3) is set. irq is high exactly while the warning flag is set and enable is committed.
- R8: When a decrement brings the counter to zero, the time-out flag is set. With reset-enable committed, rst_req pulses high for exactly one cycle. Without it, rst_req stays low.
- R9: A valid key sequence that arrives while the watchdog runs and the counter is above the window value is a feed error. It does not reload the counter.
- R10: With protect clear, the reload register can be written at any time. With protect committed, a reload write is refused and sets the time-out flag unless the counter is below both the warning and the window values.
- R11: Writing 0 to mode bit 2 or bit 3 clears that flag. Writing 1 to either flag has no effect. A flag set event in the same cycle wins over a clear.
- R12: With reset-enable committed, any fault (time-out, feed error, refused reload) causes a watchdog reset. Every register, the kick sequence and the counter return to their reset values, except that the time-out flag is left set.
- R13: osc_lock follows the committed lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External asynchronous reset, active low |
| tick | input | 1 | Count strobe; one decrement per cycle it is high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Warning interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| osc_lock | output | 1 | Committed lock bit, holds the watchdog clock source on |

## Verification
The assertions assume that a write to the kick register is the only bus action that can raise the counter. They also assume rst_n is held low long enough for every register to take its reset value. The stimulus keeps to this: reloads happen only through key sequences or faults, and reset is held for several clock edges. The kick test values are picked so that the counter is already at or below the window value whenever a kick is meant to succeed, and above it when a kick is meant to fail. This keeps the sticky-bit and one-cycle-pulse properties away from ambiguous edge cases.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
    // Register word addresses.
    localparam logic [2:0] A_MODE   = 3'd0;
    localparam logic [2:0] A_RELOAD = 3'd1;
    localparam logic [2:0] A_WARN   = 3'd2;
    localparam logic [2:0] A_WINDOW = 3'd3;
    localparam logic [2:0] A_KICK   = 3'd4;
    localparam logic [2:0] A_COUNT  = 3'd5;

    // Mode register bit positions.
    localparam int B_EN   = 0;
    localparam int B_RST  = 1;
    localparam int B_TOF  = 2;
    localparam int B_WARN = 3;
    localparam int B_PROT = 4;
    localparam int B_LOCK = 5;

    // Kick key bytes.
    localparam logic [7:0] KEY_ARM  = 8'hAA;
    localparam logic [7:0] KEY_FIRE = 8'h55;

    typedef struct packed {
        logic lock;
        logic prot;
        logic rsten;
        logic en;
    } mode_t;

    typedef enum logic [1:0] {
        KICK_IDLE,
        KICK_GOOD,
        KICK_BAD
    } kick_e;
endpackage

// File: rtl/wwd_kick_seq.sv
module wwd_kick_seq
    import wwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_clr,
    input  logic       wr,
    input  logic       is_kick,
    input  logic [7:0] key,
    output kick_e      res
);
    typedef struct packed {
        logic armed;
    } kstate_t;

    kstate_t q, d;

    always_comb begin
        d   = q;
        res = KICK_IDLE;
        if (wr) begin
            if (q.armed) begin
                // Sequence is open: the very next write decides it.
                d.armed = 1'b0;
                res     = (is_kick && key == KEY_FIRE) ? KICK_GOOD : KICK_BAD;
            end else if (is_kick) begin
                if (key == KEY_ARM) d.armed = 1'b1;
                else                res     = KICK_BAD;
            end
        end
        if (soft_clr) d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wwd_down_counter.sv
module wwd_down_counter #(
    parameter int unsigned CW   = 16,
    parameter int unsigned INIT = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] warn_val,
    output logic [CW-1:0] cnt,
    output logic          hit_warn,
    output logic          hit_zero
);
    localparam logic [CW-1:0] CNT_INIT = CW'(INIT);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cstate_t;

    cstate_t       q, d;
    logic          step;
    logic [CW-1:0] dec;

    assign step     = run && tick && !load && (q.cnt != '0);
    assign dec      = q.cnt - ONE;
    assign hit_warn = step && (dec == warn_val);
    assign hit_zero = step && (dec == '0);
    assign cnt      = q.cnt;

    always_comb begin
        d = q;
        if (soft_clr)  d.cnt = CNT_INIT;
        else if (load) d.cnt = load_val;
        else if (step) d.cnt = dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.cnt <= CNT_INIT;
        else        q     <= d;
    end
endmodule

// File: rtl/wwd_top.sv
module wwd_top
    import wwd_pkg::*;
#(
    parameter int unsigned CW         = 16,
    parameter int unsigned RST_RELOAD = 255
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        rst_req,
    output logic        osc_lock
);
    localparam logic [CW-1:0] RELOAD_INIT = CW'(RST_RELOAD);

    typedef struct packed {
        mode_t         act;
        mode_t         pend;
        logic          tof;
        logic          wflag;
        logic [CW-1:0] reload;
        logic [CW-1:0] warn;
        logic [CW-1:0] window;
        logic          rreq;
    } regs_t;

    localparam regs_t REGS_INIT = '{
        act:    '0,
        pend:   '0,
        tof:    1'b0,
        wflag:  1'b0,
        reload: RELOAD_INIT,
        warn:   '0,
        window: '1,
        rreq:   1'b0
    };

    regs_t         q, d;
    kick_e         kick_res;
    logic [CW-1:0] cnt;
    logic          hit_warn, hit_zero;
    logic          wr_mode, wr_reload, wr_warn, wr_window, wr_kick;
    logic          feed_ok, feed_load, reload_ok, reload_bad, fault, soft_clr;
    logic          unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_mode   = bus_wr && (bus_addr == A_MODE);
    assign wr_reload = bus_wr && (bus_addr == A_RELOAD);
    assign wr_warn   = bus_wr && (bus_addr == A_WARN);
    assign wr_window = bus_wr && (bus_addr == A_WINDOW);
    assign wr_kick   = bus_wr && (bus_addr == A_KICK);

    wwd_kick_seq u_kick (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr       (bus_wr),
        .is_kick  (wr_kick),
        .key      (bus_wdata[7:0]),
        .res      (kick_res)
    );

    wwd_down_counter #(
        .CW   (CW),
        .INIT (RST_RELOAD)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .load     (feed_load),
        .load_val (q.reload),
        .run      (q.act.en),
        .tick     (tick),
        .warn_val (q.warn),
        .cnt      (cnt),
        .hit_warn (hit_warn),
        .hit_zero (hit_zero)
    );

    // Early kick: the watchdog is running and the count is still above the window.
    assign feed_ok    = !(q.act.en && (cnt > q.window));
    assign feed_load  = (kick_res == KICK_GOOD) && feed_ok;
    assign reload_ok  = (cnt < q.warn) && (cnt < q.window);
    assign reload_bad = wr_reload && q.act.prot && !reload_ok;
    assign fault      = hit_zero || (kick_res == KICK_BAD) ||
                        ((kick_res == KICK_GOOD) && !feed_ok) || reload_bad;
    assign soft_clr   = fault && q.act.rsten;

    always_comb begin
        d      = q;
        d.rreq = 1'b0;
        if (wr_mode) begin
            d.pend.en    = q.pend.en    | bus_wdata[B_EN];
            d.pend.rsten = q.pend.rsten | bus_wdata[B_RST];
            d.pend.prot  = q.pend.prot  | bus_wdata[B_PROT];
            d.pend.lock  = q.pend.lock  | bus_wdata[B_LOCK];
            if (!bus_wdata[B_TOF])  d.tof   = 1'b0;
            if (!bus_wdata[B_WARN]) d.wflag = 1'b0;
        end
        if (wr_reload && !reload_bad) d.reload = bus_wdata[CW-1:0];
        if (wr_warn)                  d.warn   = bus_wdata[CW-1:0];
        if (wr_window)                d.window = bus_wdata[CW-1:0];
        if (feed_load)                d.act    = q.pend;
        if (hit_warn)                 d.wflag  = 1'b1;
        if (fault)                    d.tof    = 1'b1;
        if (soft_clr) begin
            d      = REGS_INIT;
            d.tof  = 1'b1;
            d.rreq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_INIT;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: begin
                bus_rdata[B_EN]   = q.act.en;
                bus_rdata[B_RST]  = q.act.rsten;
                bus_rdata[B_TOF]  = q.tof;
                bus_rdata[B_WARN] = q.wflag;
                bus_rdata[B_PROT] = q.act.prot;
                bus_rdata[B_LOCK] = q.act.lock;
            end
            A_RELOAD: bus_rdata = 32'(q.reload);
            A_WARN:   bus_rdata = 32'(q.warn);
            A_WINDOW: bus_rdata = 32'(q.window);
            A_COUNT:  bus_rdata = 32'(cnt);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq      = q.wflag && q.act.en;
    assign rst_req  = q.rreq;
    assign osc_lock = q.act.lock;
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic          irq,
    input logic          rst_req,
    input logic          osc_lock,
    input logic          en_act,
    input logic          rsten_act,
    input logic [CW-1:0] cnt
);
    logic kick_wr;
    assign kick_wr = bus_wr && (bus_addr == 3'd4);

    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(rsten_act));

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        osc_lock |=> (osc_lock || rst_req));

    assert_en_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_act |=> (en_act || rst_req));

    assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!en_act && !irq && !osc_lock));

    assert_no_climb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !kick_wr |=> (rst_req || cnt <= $past(cnt)));
endmodule

bind wwd_top wwd_checker #(.CW(CW)) u_wwd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .irq       (irq),
    .rst_req   (rst_req),
    .osc_lock  (osc_lock),
    .en_act    (q.act.en),
    .rsten_act (q.act.rsten),
    .cnt       (cnt)
);

// File: tb/tb_wwd_top.sv
module tb_wwd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req, osc_lock;

    int    checks = 0;
    int    errors = 0;
    int    pulses = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state.
    bit m_en, m_rst, m_prot, m_lock;
    bit p_en, p_rst, p_prot, p_lock;
    bit m_tof, m_wf, m_armed, m_rreq;
    int m_reload, m_warn, m_win, m_cnt;

    always #10 clk = ~clk;   // 50 MHz

    wwd_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req),
        .osc_lock  (osc_lock)
    );

    task automatic model_clear();
        m_en = 0; m_rst = 0; m_prot = 0; m_lock = 0;
        p_en = 0; p_rst = 0; p_prot = 0; p_lock = 0;
        m_tof = 0; m_wf = 0; m_armed = 0; m_rreq = 0;
        m_reload = 255; m_warn = 0; m_win = 65535; m_cnt = 255;
    endtask

    task automatic model_step();
        bit fault = 0;
        bit good = 0;
        bit load = 0;
        bit old_en = m_en;
        bit old_rst = m_rst;
        bit old_prot = m_prot;
        int c = m_cnt;
        m_rreq = 0;
        if (bus_wr) begin
            if (bus_addr == 3'd0) begin
                if (bus_wdata[0]) p_en = 1;
                if (bus_wdata[1]) p_rst = 1;
                if (bus_wdata[4]) p_prot = 1;
                if (bus_wdata[5]) p_lock = 1;
                if (!bus_wdata[2]) m_tof = 0;
                if (!bus_wdata[3]) m_wf = 0;
            end
            if (bus_addr == 3'd1) begin
                if (old_prot && !(c < m_warn && c < m_win)) fault = 1;
                else m_reload = int'(bus_wdata[15:0]);
            end
            if (bus_addr == 3'd2) m_warn = int'(bus_wdata[15:0]);
            if (bus_addr == 3'd3) m_win = int'(bus_wdata[15:0]);
            if (m_armed) begin
                m_armed = 0;
                if (bus_addr == 3'd4 && bus_wdata[7:0] == 8'h55) good = 1;
                else fault = 1;
            end else if (bus_addr == 3'd4) begin
                if (bus_wdata[7:0] == 8'hAA) m_armed = 1;
                else fault = 1;
            end
        end
        if (good) begin
            if (old_en && c > m_win) fault = 1;
            else begin
                load = 1;
                m_en = p_en; m_rst = p_rst; m_prot = p_prot; m_lock = p_lock;
            end
        end
        if (!load && old_en && tick && c > 0) begin
            m_cnt = c - 1;
            if (m_cnt == m_warn) m_wf = 1;
            if (m_cnt == 0) fault = 1;
        end
        if (load) m_cnt = m_reload;
        if (fault) m_tof = 1;
        if (fault && old_rst) begin
            model_clear();
            m_tof = 1;
            m_rreq = 1;
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return {26'd0, m_lock, m_prot, m_wf, m_tof, m_rst, m_en};
            3'd1:    return 32'(m_reload);
            3'd2:    return 32'(m_warn);
            3'd3:    return 32'(m_win);
            3'd5:    return 32'(m_cnt);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model_clear();
        else        model_step();
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "model rdata", bus_rdata, model_read(bus_addr));
            check(cur_req, "model irq", 32'(irq), 32'(m_wf && m_en));
            check(cur_req, "model rst_req", 32'(rst_req), 32'(m_rreq));
            check(cur_req, "model osc_lock", 32'(osc_lock), 32'(m_lock));
        end
        if (rst_req) pulses++;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic kick();
        wr(3'd4, 32'hAA);
        wr(3'd4, 32'h55);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
        end
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a,
                              input logic [31:0] exp);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        check(req, $sformatf("reg %0d", a), bus_rdata, exp);
    endtask

    task automatic expect_pin(input string req, input string what,
                              input logic v, input logic exp);
        @(negedge clk);
        check(req, what, 32'(v), 32'(exp));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        cur_req = "R1";
        expect_reg("R1", 3'd0, 32'h0);
        expect_reg("R1", 3'd1, 32'd255);
        expect_reg("R1", 3'd5, 32'd255);
        expect_reg("R1", 3'd2, 32'd0);
        expect_reg("R1", 3'd3, 32'hFFFF);
        expect_pin("R1", "rst_req", rst_req, 1'b0);

        cur_req = "R3";
        wr(3'd1, 32'd20);
        wr(3'd0, 32'h01);
        expect_reg("R3", 3'd0, 32'h0);
        ticks(3);
        expect_reg("R3", 3'd5, 32'd255);

        cur_req = "R4";
        kick();
        expect_reg("R4", 3'd0, 32'h01);
        expect_reg("R4", 3'd5, 32'd20);

        cur_req = "R6";
        ticks(5);
        expect_reg("R6", 3'd5, 32'd15);

        cur_req = "R2";
        wr(3'd0, 32'h00);
        kick();
        expect_reg("R2", 3'd0, 32'h01);

        cur_req = "R7";
        wr(3'd2, 32'd10);
        ticks(9);
        expect_reg("R7", 3'd0, 32'h01);
        expect_pin("R7", "irq before warn", irq, 1'b0);
        ticks(1);
        expect_reg("R7", 3'd0, 32'h09);
        expect_pin("R7", "irq at warn", irq, 1'b1);

        cur_req = "R11";
        wr(3'd0, 32'h04);
        expect_reg("R11", 3'd0, 32'h01);
        expect_pin("R11", "irq after clear", irq, 1'b0);

        cur_req = "R8";
        ticks(12);
        expect_reg("R6", 3'd5, 32'd0);
        expect_reg("R8", 3'd0, 32'h05);
        check("R8", "no pulse without reset-enable", 32'(pulses), 32'd0);
        wr(3'd0, 32'h00);
        expect_reg("R11", 3'd0, 32'h01);

        cur_req = "R5";
        wr(3'd4, 32'hAA);
        wr(3'd2, 32'd10);
        expect_reg("R5", 3'd0, 32'h05);
        wr(3'd0, 32'h00);
        wr(3'd4, 32'hAA);
        wr(3'd4, 32'h12);
        expect_reg("R5", 3'd0, 32'h05);
        wr(3'd0, 32'h00);
        wr(3'd4, 32'h55);
        expect_reg("R5", 3'd0, 32'h05);
        wr(3'd0, 32'h00);

        cur_req = "R9";
        wr(3'd3, 32'd8);
        kick();
        expect_reg("R9", 3'd5, 32'd20);
        kick();
        expect_reg("R9", 3'd0, 32'h05);
        expect_reg("R9", 3'd5, 32'd20);
        wr(3'd0, 32'h00);
        ticks(13);
        expect_reg("R9", 3'd5, 32'd7);
        kick();
        expect_reg("R9", 3'd5, 32'd20);
        expect_reg("R9", 3'd0, 32'h09);
        wr(3'd0, 32'h00);

        cur_req = "R10";
        wr(3'd1, 32'd22);
        expect_reg("R10", 3'd1, 32'd22);
        wr(3'd0, 32'h10);
        ticks(12);
        kick();
        expect_reg("R10", 3'd0, 32'h19);
        wr(3'd0, 32'h00);
        wr(3'd1, 32'd30);
        expect_reg("R10", 3'd1, 32'd22);
        expect_reg("R10", 3'd0, 32'h15);
        wr(3'd0, 32'h00);
        ticks(15);
        expect_reg("R10", 3'd5, 32'd7);
        wr(3'd1, 32'd30);
        expect_reg("R10", 3'd1, 32'd30);
        expect_reg("R10", 3'd0, 32'h19);
        wr(3'd0, 32'h00);

        cur_req = "R13";
        wr(3'd0, 32'h20);
        expect_pin("R13", "osc_lock before kick", osc_lock, 1'b0);
        kick();
        expect_pin("R13", "osc_lock after kick", osc_lock, 1'b1);
        expect_reg("R13", 3'd0, 32'h31);

        cur_req = "R12";
        wr(3'd0, 32'h02);
        ticks(22);
        kick();
        expect_reg("R12", 3'd0, 32'h3B);
        wr(3'd0, 32'h00);
        expect_reg("R12", 3'd0, 32'h33);
        wr(3'd4, 32'hAA);
        wr(3'd4, 32'h00);
        expect_reg("R12", 3'd0, 32'h04);
        expect_reg("R12", 3'd5, 32'd255);
        expect_reg("R12", 3'd1, 32'd255);
        expect_reg("R12", 3'd3, 32'hFFFF);
        expect_pin("R12", "osc_lock cleared", osc_lock, 1'b0);
        check("R12", "reset pulses", 32'(pulses), 32'd1);

        cur_req = "R8";
        wr(3'd1, 32'd3);
        wr(3'd0, 32'h03);
        kick();
        wr(3'd0, 32'h03);
        expect_reg("R8", 3'd0, 32'h03);
        ticks(3);
        expect_reg("R8", 3'd0, 32'h04);
        check("R8", "time-out pulse count", 32'(pulses), 32'd2);

        cur_req = "R1";
        do_reset();
        expect_reg("R1", 3'd0, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule